// File: doc/BRIEF.md
# HDLC Receive Address Filter with Frame Statistics

This block sits behind an HDLC receive deframer that has already removed flags and stuffed bits. For every incoming frame it captures the first two octets as a 16-bit station address and compares them against a bank of programmable addresses. The compare uses a shared bit mask, and the block presents an accept/reject decision for the frame. It also tracks the byte count of the frame against a programmable maximum length and raises a sticky oversize flag.

At the end of each frame the deframer pulses a status strobe with three qualifiers: CRC failure, abort seen, and no receive buffer free. The block keeps four wrapping 16-bit event counters from these strobes. Three of them count CRC failures, aborts and discards. The fourth counts clean frames whose address matched no entry. Software can zero any counter with a clear strobe.

Top module: `hdlc_addr_filter`

## Requirements
- R1: While `rst_n` is low, `decision_vld`, `accept`, `len_viol` and all four counters are zero.
- R2: The first data byte after `frm_start` is compared against bits 15:8 of the mask and address entries, and the second byte against bits 7:0.
- R3: A mask bit of 1 includes that address bit in the compare; a mask bit of 0 makes the bit a don't-care.
- R4: The frame is accepted when its masked address equals the masked value of any of the four address entries; entry i sits in `cfg_addr` bits 16*i+15 to 16*i.
- R5: `decision_vld` rises, and `accept` takes its value, one clock after the second byte is taken. Both hold until the next `frm_start`, which clears them in the following cycle.
- R6: `len_viol` sets once the number of bytes taken in the current frame exceeds `cfg_max_len`. It stays set until `frm_start` clears it.
- R7: An end-of-frame strobe with `eof_abort` high increments `cnt_abort` by one.
- R8: An end-of-frame strobe with `eof_crc_err` high increments `cnt_crc` only if `eof_abort` is low.
- R9: An end-of-frame strobe with `eof_no_buf` high increments `cnt_discard`.
- R10: `cnt_nomatch` increments on an end-of-frame strobe only if all three status bits are low, `decision_vld` is high and `accept` is low.
- R11: Every counter wraps from 16'hFFFF to 0.
- R12: `cnt_clr` bit 0 zeroes `cnt_crc`, bit 1 zeroes `cnt_abort`, bit 2 zeroes `cnt_discard`, and bit 3 zeroes `cnt_nomatch`. A clear wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | Start-of-frame strobe |
| byte_vld | input | 1 | Received byte valid |
| byte_data | input | 8 | Received byte |
| eof_vld | input | 1 | End-of-frame status strobe |
| eof_crc_err | input | 1 | Frame failed its CRC |
| eof_abort | input | 1 | Abort sequence seen in frame |
| eof_no_buf | input | 1 | Frame dropped, no buffer free |
| cfg_mask | input | 16 | Address compare mask |
| cfg_addr | input | 64 | Four 16-bit address entries |
| cfg_max_len | input | 16 | Largest allowed frame length in bytes |
| cnt_clr | input | 4 | Per-counter clear strobes |
| decision_vld | output | 1 | Address decision available |
| accept | output | 1 | Frame address matched |
| len_viol | output | 1 | Frame longer than allowed |
| cnt_crc | output | 16 | CRC failure count |
| cnt_abort | output | 16 | Abort count |
| cnt_discard | output | 16 | No-buffer discard count |
| cnt_nomatch | output | 16 | Clean non-matching frame count |

## Verification
The assertions rely on the deframer never pulsing `frm_start`, `byte_vld` and `eof_vld` in the same cycle. They also require the mask, address and length settings to stay constant within a frame. The bench drives at most one strobe per clock through its frame, byte and status tasks. It rewrites the settings only between a status strobe and the next frame start. Under these conditions a decision, once valid, can change only at a frame start.

// File: rtl/haf_pkg.sv
package haf_pkg;
   localparam int BYTE_W = 8;
   localparam int NUM_EV = 4;
   typedef enum logic [1:0] {
      EV_CRC     = 2'd0,
      EV_ABORT   = 2'd1,
      EV_DISCARD = 2'd2,
      EV_NOMATCH = 2'd3
   } ev_e;
endpackage

// File: rtl/haf_addr_match.sv
module haf_addr_match #(
   parameter int NUM_ADDR = 4,
   parameter int AW       = 16
) (
   input  logic [AW-1:0]          cand,
   input  logic [AW-1:0]          mask,
   input  logic [NUM_ADDR*AW-1:0] table_flat,
   output logic                   hit
);
   logic [NUM_ADDR-1:0] hit_vec;

   for (genvar i = 0; i < NUM_ADDR; i++) begin : g_entry
      assign hit_vec[i] = ((cand ^ table_flat[i*AW +: AW]) & mask) == '0;
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/haf_len_track.sv
module haf_len_track #(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frm_start,
   input  logic             byte_vld,
   input  logic [LEN_W-1:0] max_len,
   output logic [LEN_W:0]   byte_cnt,
   output logic             len_viol
);
   localparam int CW = LEN_W + 1;

   logic at_top;
   logic over_next;

   assign at_top    = &byte_cnt;
   assign over_next = byte_cnt >= {1'b0, max_len};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_cnt <= '0;
         len_viol <= 1'b0;
      end else if (frm_start) begin
         byte_cnt <= '0;
         len_viol <= 1'b0;
      end else if (byte_vld) begin
         if (!at_top) byte_cnt <= byte_cnt + CW'(1);
         if (over_next) len_viol <= 1'b1;
      end
   end
endmodule

// File: rtl/haf_event_ctr.sv
module haf_event_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter #(
   parameter int NUM_ADDR = 4,
   parameter int CNT_W    = 16,
   parameter int LEN_W    = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            frm_start,
   input  logic                            byte_vld,
   input  logic [haf_pkg::BYTE_W-1:0]      byte_data,
   input  logic                            eof_vld,
   input  logic                            eof_crc_err,
   input  logic                            eof_abort,
   input  logic                            eof_no_buf,
   input  logic [2*haf_pkg::BYTE_W-1:0]    cfg_mask,
   input  logic [NUM_ADDR*2*haf_pkg::BYTE_W-1:0] cfg_addr,
   input  logic [LEN_W-1:0]                cfg_max_len,
   input  logic [haf_pkg::NUM_EV-1:0]      cnt_clr,
   output logic                            decision_vld,
   output logic                            accept,
   output logic                            len_viol,
   output logic [CNT_W-1:0]                cnt_crc,
   output logic [CNT_W-1:0]                cnt_abort,
   output logic [CNT_W-1:0]                cnt_discard,
   output logic [CNT_W-1:0]                cnt_nomatch
);
   import haf_pkg::*;

   localparam int AW = 2 * BYTE_W;

   initial begin
      assert (NUM_ADDR >= 1) else $error("NUM_ADDR must be at least 1");
      assert (CNT_W >= 1)    else $error("CNT_W must be at least 1");
      assert (LEN_W >= 2)    else $error("LEN_W must be at least 2");
   end

   logic [LEN_W:0]       byte_cnt;
   logic [BYTE_W-1:0]    first_q;
   logic                 hit;
   logic                 clean_eof;
   logic [NUM_EV-1:0]    ev_inc;
   logic [CNT_W-1:0]     ev_cnt [NUM_EV];

   haf_len_track #(.LEN_W(LEN_W)) u_len (
      .clk       (clk),
      .rst_n     (rst_n),
      .frm_start (frm_start),
      .byte_vld  (byte_vld),
      .max_len   (cfg_max_len),
      .byte_cnt  (byte_cnt),
      .len_viol  (len_viol)
   );

   // first octet lands in the upper half of the compare word
   haf_addr_match #(.NUM_ADDR(NUM_ADDR), .AW(AW)) u_match (
      .cand       ({first_q, byte_data}),
      .mask       (cfg_mask),
      .table_flat (cfg_addr),
      .hit        (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q      <= '0;
         decision_vld <= 1'b0;
         accept       <= 1'b0;
      end else if (frm_start) begin
         decision_vld <= 1'b0;
         accept       <= 1'b0;
      end else if (byte_vld) begin
         if (byte_cnt == '0) first_q <= byte_data;
         if (byte_cnt == (LEN_W+1)'(1)) begin
            decision_vld <= 1'b1;
            accept       <= hit;
         end
      end
   end

   assign clean_eof = eof_vld & ~eof_crc_err & ~eof_abort & ~eof_no_buf;

   always_comb begin
      ev_inc             = '0;
      ev_inc[EV_ABORT]   = eof_vld & eof_abort;
      ev_inc[EV_CRC]     = eof_vld & eof_crc_err & ~eof_abort;
      ev_inc[EV_DISCARD] = eof_vld & eof_no_buf;
      ev_inc[EV_NOMATCH] = clean_eof & decision_vld & ~accept;
   end

   for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
      haf_event_ctr #(.CNT_W(CNT_W)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (ev_inc[e]),
         .clr   (cnt_clr[e]),
         .cnt   (ev_cnt[e])
      );
   end

   assign cnt_crc     = ev_cnt[EV_CRC];
   assign cnt_abort   = ev_cnt[EV_ABORT];
   assign cnt_discard = ev_cnt[EV_DISCARD];
   assign cnt_nomatch = ev_cnt[EV_NOMATCH];
endmodule

// File: rtl/haf_checker.sv
module haf_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frm_start,
   input logic             byte_vld,
   input logic             eof_vld,
   input logic             eof_crc_err,
   input logic             eof_abort,
   input logic [3:0]       cnt_clr,
   input logic             decision_vld,
   input logic             accept,
   input logic             len_viol,
   input logic [CNT_W-1:0] cnt_crc,
   input logic [CNT_W-1:0] cnt_abort,
   input logic [CNT_W-1:0] cnt_nomatch
);
   assert_accept_implies_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> decision_vld);

   assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frm_start |=> (!decision_vld && !accept && !len_viol));

   assert_decision_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (decision_vld && !frm_start) |=> (decision_vld && $stable(accept)));

   assert_viol_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (len_viol && !frm_start) |=> len_viol);

   assert_viol_needs_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!len_viol && !byte_vld) |=> !len_viol);

   assert_abort_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_vld && eof_abort && !cnt_clr[1]) |=> (cnt_abort == CNT_W'($past(cnt_abort) + 1'b1)));

   assert_crc_masked_by_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_vld && eof_abort && !cnt_clr[0]) |=> $stable(cnt_crc));

   assert_nomatch_needs_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_vld && eof_crc_err && !cnt_clr[3]) |=> $stable(cnt_nomatch));

   assert_clear_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr[3] |=> (cnt_nomatch == '0));
endmodule

bind hdlc_addr_filter haf_checker #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frm_start    (frm_start),
   .byte_vld     (byte_vld),
   .eof_vld      (eof_vld),
   .eof_crc_err  (eof_crc_err),
   .eof_abort    (eof_abort),
   .cnt_clr      (cnt_clr),
   .decision_vld (decision_vld),
   .accept       (accept),
   .len_viol     (len_viol),
   .cnt_crc      (cnt_crc),
   .cnt_abort    (cnt_abort),
   .cnt_nomatch  (cnt_nomatch)
);

// File: tb/hdlc_addr_filter_tb.sv
`timescale 1ns/1ps
module hdlc_addr_filter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_start = 1'b0, byte_vld = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        eof_vld = 1'b0, eof_crc_err = 1'b0, eof_abort = 1'b0, eof_no_buf = 1'b0;
   logic [15:0] cfg_mask = 16'hFFFF;
   logic [63:0] cfg_addr = '0;
   logic [15:0] cfg_max_len = 16'd6;
   logic [3:0]  cnt_clr = '0;
   logic        decision_vld, accept, len_viol;
   logic [15:0] cnt_crc, cnt_abort, cnt_discard, cnt_nomatch;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   hdlc_addr_filter dut_i (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   int          m_idx;
   logic [7:0]  m_first;
   logic        m_dvld, m_acc, m_lv;
   logic [15:0] m_c [4];   // 0 crc, 1 abort, 2 discard, 3 nomatch

   function automatic logic addr_hit(logic [15:0] a);
      for (int i = 0; i < 4; i++)
         if (((a ^ cfg_addr[i*16 +: 16]) & cfg_mask) == 16'h0) return 1'b1;
      return 1'b0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_idx = 0; m_first = 0; m_dvld = 0; m_acc = 0; m_lv = 0;
         for (int i = 0; i < 4; i++) m_c[i] = 16'h0;
      end else begin
         if (eof_vld) begin
            if (eof_abort) m_c[1] = m_c[1] + 16'd1;
            else if (eof_crc_err) m_c[0] = m_c[0] + 16'd1;
            if (eof_no_buf) m_c[2] = m_c[2] + 16'd1;
            if (!eof_abort && !eof_crc_err && !eof_no_buf && m_dvld && !m_acc)
               m_c[3] = m_c[3] + 16'd1;
         end
         for (int i = 0; i < 4; i++) if (cnt_clr[i]) m_c[i] = 16'h0;
         if (frm_start) begin
            m_idx = 0; m_dvld = 0; m_acc = 0; m_lv = 0;
         end else if (byte_vld) begin
            if (m_idx == 0) m_first = byte_data;
            if (m_idx == 1) begin
               m_dvld = 1;
               m_acc  = addr_hit({m_first, byte_data});
            end
            m_idx++;
            if (m_idx > int'(cfg_max_len)) m_lv = 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 accept",        {31'd0, accept},       {31'd0, m_acc});
         chk("R5 decision_vld",  {31'd0, decision_vld}, {31'd0, m_dvld});
         chk("R6 len_viol",      {31'd0, len_viol},     {31'd0, m_lv});
         chk("R8 cnt_crc",       {16'd0, cnt_crc},      {16'd0, m_c[0]});
         chk("R7 cnt_abort",     {16'd0, cnt_abort},    {16'd0, m_c[1]});
         chk("R9 cnt_discard",   {16'd0, cnt_discard},  {16'd0, m_c[2]});
         chk("R10 cnt_nomatch",  {16'd0, cnt_nomatch},  {16'd0, m_c[3]});
      end
   end

   // ---------------- stimulus ----------------
   task automatic tick(); @(posedge clk); #1; endtask

   task automatic start_frame();
      frm_start = 1'b1; tick(); frm_start = 1'b0;
   endtask

   task automatic put_byte(logic [7:0] b);
      byte_vld = 1'b1; byte_data = b; tick(); byte_vld = 1'b0;
   endtask

   task automatic end_frame(logic c, logic a, logic n);
      eof_vld = 1'b1; eof_crc_err = c; eof_abort = a; eof_no_buf = n;
      tick();
      eof_vld = 1'b0; eof_crc_err = 1'b0; eof_abort = 1'b0; eof_no_buf = 1'b0;
   endtask

   task automatic frame(logic [7:0] b0, logic [7:0] b1, int len);
      start_frame();
      put_byte(b0);
      put_byte(b1);
      for (int i = 2; i < len; i++) put_byte(8'(i));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      cfg_addr = {16'h8001, 16'h0F0F, 16'hABCD, 16'h1234};
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1 reset state", {decision_vld, accept, len_viol},
          3'b000);
      chk("R1 reset counters", {cnt_crc, cnt_abort}, 32'h0);
      chk("R1 reset counters", {cnt_discard, cnt_nomatch}, 32'h0);
      @(posedge clk); #1 rst_n = 1'b1;
      tick();

      // R2/R4: byte order and any-entry match
      frame(8'h12, 8'h34, 4);
      chk("R2 first byte high half accepted", {31'd0, accept}, 32'd1);
      end_frame(0, 0, 0);
      frame(8'h34, 8'h12, 4);
      chk("R2 swapped bytes rejected", {30'd0, decision_vld, accept}, 32'd2);
      end_frame(0, 0, 0);
      chk("R10 clean reject counted", {16'd0, cnt_nomatch}, 32'd1);
      frame(8'h80, 8'h01, 3);
      chk("R4 last entry matches", {31'd0, accept}, 32'd1);
      end_frame(0, 0, 0);
      frame(8'hAB, 8'hCD, 2);
      chk("R4 second entry matches", {31'd0, accept}, 32'd1);
      end_frame(0, 0, 0);

      // R3: masked compare
      cfg_mask = 16'hFF00;
      frame(8'h12, 8'h99, 3);
      chk("R3 low half ignored", {31'd0, accept}, 32'd1);
      end_frame(0, 0, 0);
      cfg_mask = 16'h00FF;
      frame(8'h77, 8'hCD, 3);
      chk("R3 high half ignored", {31'd0, accept}, 32'd1);
      end_frame(0, 0, 0);
      cfg_mask = 16'hFFFF;

      // R6: oversize
      frame(8'h12, 8'h34, 6);
      chk("R6 exactly max length", {31'd0, len_viol}, 32'd0);
      put_byte(8'h55);
      chk("R6 one over max", {31'd0, len_viol}, 32'd1);
      end_frame(0, 0, 0);
      start_frame();
      chk("R6 cleared by start", {31'd0, len_viol}, 32'd0);

      // status combinations R7 R8 R9 R10
      put_byte(8'h00); put_byte(8'h00);
      end_frame(1, 1, 0);
      chk("R8 crc masked by abort", {16'd0, cnt_crc}, 32'd0);
      chk("R7 abort counted", {16'd0, cnt_abort}, 32'd1);
      frame(8'h00, 8'h00, 2);
      end_frame(1, 0, 0);
      chk("R8 crc counted", {16'd0, cnt_crc}, 32'd1);
      frame(8'h00, 8'h00, 2);
      end_frame(0, 0, 1);
      chk("R9 discard counted", {16'd0, cnt_discard}, 32'd1);
      start_frame(); put_byte(8'h00);
      end_frame(0, 0, 0);
      chk("R10 no decision not counted", {16'd0, cnt_nomatch}, 32'd1);

      // R12: clear beats increment
      cnt_clr = 4'b1010; eof_vld = 1'b1; eof_abort = 1'b1;
      tick();
      cnt_clr = 4'b0000; eof_vld = 1'b0; eof_abort = 1'b0;
      chk("R12 clear abort", {16'd0, cnt_abort}, 32'd0);
      chk("R12 clear nomatch", {16'd0, cnt_nomatch}, 32'd0);
      chk("R12 other counters kept", {16'd0, cnt_crc}, 32'd1);

      // R11: wrap
      eof_vld = 1'b1; eof_abort = 1'b1;
      repeat (65535) tick();
      eof_vld = 1'b0; eof_abort = 1'b0;
      chk("R11 reaches top", {16'd0, cnt_abort}, 32'h0000FFFF);
      end_frame(0, 1, 0);
      chk("R11 wraps to zero", {16'd0, cnt_abort}, 32'd0);

      tick(); tick();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule